// File: doc/BRIEF.md
# Grouped Polled Interrupt Controller

This block collects interrupt events for a small 8-bit processor and presents them through a byte-wide register bus. Sources are arranged into three maskable IRQ groups and one NMI group. Every source owns a sticky request bit that is captured whenever its trigger fires, whether or not the source is enabled. Each source also has an enable bit that software can read back. Software finds the cause of an interrupt by polling. It first reads a summary byte that holds one bit per group, then reads the request register of the group that is flagged. It clears a serviced request by writing a one to that bit position.

Single-cycle event strobes from on-chip peripherals feed the requests directly. Three external pins (vertical sync, external input 0 and external input 1) pass through a two-flop synchroniser and an edge detector first. Each of these pins can be set to react to its rising edge or its falling edge. `cpu_irq` is a registered level that is high while any enabled IRQ request is pending. `cpu_nmi` is a one-cycle strobe produced by a small state machine, once for each rise of the enabled-NMI-pending condition. The state machine has three states:
- NMI_IDLE: nothing pending. It moves to NMI_FIRE when a pending enabled NMI appears.
- NMI_FIRE: the strobe cycle. It moves to NMI_HOLD if the condition is still present, and back to NMI_IDLE otherwise.
- NMI_HOLD: it waits until the condition goes away, then returns to NMI_IDLE.

Top module: `grp_poll_intc`

## Requirements
- R1: After reset every enable register and every request register reads 0x00, the summary byte reads 0x00, the edge-select register (0x1F) reads 0xFF, and both `cpu_irq` and `cpu_nmi` are low.
- R2: The enable registers are read/write and hold only their implemented bits; all other bits read as zero. The registers are:
  - NMI enable at 0x10, mask 0x03.
  - IRQ group 0 enable at 0x11, mask 0x1F.
  - IRQ group 1 enable at 0x12, mask 0x1F.
  - IRQ group 2 enable at 0x13, mask 0x0F.
- R3: A source event sets its request bit on the next clock edge, even when its enable bit is 0. The request bits are laid out as follows:
  - IRQ group 0 at 0x1C: `ser0_evt[i]` sets bit i.
  - IRQ group 1 at 0x1D: `ser1_evt[i]` sets bit i.
  - IRQ group 2 at 0x1E: bit0 adc, bit1 vsync, bit2 ext1, bit3 timer.
  - NMI group at 0x16: bit0 ext0, bit1 mute.
- R4: Writing a byte to a request register clears exactly the bits written as 1; bits written as 0 keep their value. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: Each edge pin sets its request on the selected edge only. The edge-select register at 0x1F controls this per pin (bit0 vsync, bit1 ext0, bit2 ext1): 1 selects the rising edge, 0 the falling edge. The request is set on the third rising clock edge after the pin changes.
- R6: The summary byte at 0x17 has bit g (g = 0..2) high while any request of IRQ group g is set, and bit7 high while any NMI request is set. A summary bit drops only when every member request of its group has been cleared.
- R7: `cpu_irq` goes high one cycle after some request with its enable bit set is pending. It stays high until no such request remains, and goes low one cycle after that.
- R8: `cpu_nmi` pulses high for one cycle each time the condition "some NMI request is set with its enable set" goes from false to true. No further pulse occurs while the condition stays true. Enabling a request that is already pending counts as a rise of the condition.
- R9: Writes to the summary address 0x17 and to unmapped addresses change nothing, and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ser0_evt | input | 5 | Serial channel 0 event strobes (IRQ group 0) |
| ser1_evt | input | 5 | Serial channel 1 event strobes (IRQ group 1) |
| adc_evt | input | 1 | Converter-done strobe (IRQ group 2) |
| timer_evt | input | 1 | Base timer strobe (IRQ group 2) |
| mute_evt | input | 1 | Mute strobe (NMI group) |
| vsync_pin | input | 1 | Asynchronous vertical sync pin (IRQ group 2) |
| ext0_pin | input | 1 | Asynchronous external pin 0 (NMI group) |
| ext1_pin | input | 1 | Asynchronous external pin 1 (IRQ group 2) |
| cpu_irq | output | 1 | Maskable request level to the processor |
| cpu_nmi | output | 1 | Non-maskable request strobe to the processor |

## Verification
Two functions can land in the same cycle:
- Capturing a source event.
- A software write-one-to-clear of the same request bit.

The bench provokes this collision by raising a serial event strobe during the very cycle in which the bus writes a clear mask to that bit. It then reads the register back and expects the bit to be set. In a second case, one enabled NMI source is already pending when another enabled NMI source fires. Here the bench counts `cpu_nmi` strobes and expects none, because the pending condition never fell.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int NUM_GRP = 3;
    localparam int NMI_W   = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] A_NMI_EN   = 8'h10;
    localparam logic [ADDR_W-1:0] A_IRQ_EN0  = 8'h11;
    localparam logic [ADDR_W-1:0] A_NMI_POLL = 8'h16;
    localparam logic [ADDR_W-1:0] A_SUMMARY  = 8'h17;
    localparam logic [ADDR_W-1:0] A_IRQ_REQ0 = 8'h1C;
    localparam logic [ADDR_W-1:0] A_EDGE_SEL = 8'h1F;

    localparam int ESEL_VSYNC = 0;
    localparam int ESEL_EXT0  = 1;
    localparam int ESEL_EXT1  = 2;
    localparam int SUM_NMI_BIT = 7;

    typedef enum logic [1:0] {
        NMI_IDLE = 2'd0,
        NMI_FIRE = 2'd1,
        NMI_HOLD = 2'd2
    } nmi_state_e;

    function automatic int grp_width(input int g);
        case (g)
            0:       return 5;
            1:       return 5;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/gpic_edge_det.sv
module gpic_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic ev_o
);
    // sh[STAGES-1] is the newest synchronised sample, sh[STAGES] the one before
    logic [STAGES:0] sh;
    logic cur_s, old_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin_i};
    end

    assign cur_s = sh[STAGES-1];
    assign old_s = sh[STAGES];
    assign ev_o  = rise_sel_i ? (cur_s & ~old_s) : (~cur_s & old_s);
endmodule

// File: rtl/gpic_req_bank.sv
module gpic_req_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R4

    AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((~q_o & $past(q_o) & ~$past(clr_i)) == '0)); // R4
endmodule

// File: rtl/gpic_nmi_fsm.sv
module gpic_nmi_fsm
    import gpic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    output logic nmi_o
);
    nmi_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NMI_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE: if (pend_i)  state_d = NMI_FIRE;
            NMI_FIRE: state_d = pend_i ? NMI_HOLD : NMI_IDLE;
            NMI_HOLD: if (!pend_i) state_d = NMI_IDLE;
            default:  state_d = NMI_IDLE;
        endcase
    end

    always_comb begin
        nmi_o = (state_q == NMI_FIRE);
    end

    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o); // R8

    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(pend_i)); // R8
endmodule

// File: rtl/grp_poll_intc.sv
module grp_poll_intc
    import gpic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [4:0]        ser0_evt,
    input  logic [4:0]        ser1_evt,
    input  logic              adc_evt,
    input  logic              timer_evt,
    input  logic              mute_evt,
    input  logic              vsync_pin,
    input  logic              ext0_pin,
    input  logic              ext1_pin,
    output logic              cpu_irq,
    output logic              cpu_nmi
);
    logic [DATA_W-1:0] esel_q;
    logic vsync_ev, ext0_ev, ext1_ev;

    logic [NUM_GRP-1:0][DATA_W-1:0] grp_set, grp_en, grp_req;
    logic [NUM_GRP-1:0] grp_hit, grp_any;
    logic [NMI_W-1:0] nmi_en_q, nmi_req, nmi_set, nmi_clr;
    logic nmi_any, nmi_pend, irq_any;
    logic [DATA_W-1:0] summary;

    // edge-select register, all rising after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               esel_q <= '1;
        else if (bus_we && bus_addr == A_EDGE_SEL) esel_q <= bus_wdata;
    end

    gpic_edge_det #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst_n(rst_n), .pin_i(vsync_pin),
        .rise_sel_i(esel_q[ESEL_VSYNC]), .ev_o(vsync_ev));
    gpic_edge_det #(.STAGES(SYNC_STAGES)) u_ext0 (
        .clk(clk), .rst_n(rst_n), .pin_i(ext0_pin),
        .rise_sel_i(esel_q[ESEL_EXT0]), .ev_o(ext0_ev));
    gpic_edge_det #(.STAGES(SYNC_STAGES)) u_ext1 (
        .clk(clk), .rst_n(rst_n), .pin_i(ext1_pin),
        .rise_sel_i(esel_q[ESEL_EXT1]), .ev_o(ext1_ev));

    // source to request-bit mapping
    always_comb begin
        grp_set = '0;
        grp_set[0][4:0] = ser0_evt;
        grp_set[1][4:0] = ser1_evt;
        grp_set[2][3:0] = {timer_evt, ext1_ev, vsync_ev, adc_evt};
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int W = grp_width(g);
        localparam logic [ADDR_W-1:0] EN_ADDR  = A_IRQ_EN0 + ADDR_W'(g);
        localparam logic [ADDR_W-1:0] REQ_ADDR = A_IRQ_REQ0 + ADDR_W'(g);

        logic [W-1:0] en_q, req_q, clr;

        assign clr = (bus_we && bus_addr == REQ_ADDR) ? bus_wdata[W-1:0] : '0;

        gpic_req_bank #(.W(W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_i(grp_set[g][W-1:0]), .clr_i(clr), .q_o(req_q));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             en_q <= '0;
            else if (bus_we && bus_addr == EN_ADDR) en_q <= bus_wdata[W-1:0];
        end

        assign grp_en[g]  = DATA_W'(en_q);
        assign grp_req[g] = DATA_W'(req_q);
        assign grp_hit[g] = |(req_q & en_q);
        assign grp_any[g] = |req_q;

        AST_SUMMARY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grp_any[g]) |-> $past(bus_we && bus_addr == REQ_ADDR)); // R6
    end

    // NMI group
    assign nmi_set = {mute_evt, ext0_ev};
    assign nmi_clr = (bus_we && bus_addr == A_NMI_POLL) ? bus_wdata[NMI_W-1:0] : '0;

    gpic_req_bank #(.W(NMI_W)) u_nmi_bank (
        .clk(clk), .rst_n(rst_n), .set_i(nmi_set), .clr_i(nmi_clr), .q_o(nmi_req));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              nmi_en_q <= '0;
        else if (bus_we && bus_addr == A_NMI_EN) nmi_en_q <= bus_wdata[NMI_W-1:0];
    end

    assign nmi_any  = |nmi_req;
    assign nmi_pend = |(nmi_req & nmi_en_q);

    gpic_nmi_fsm u_nmi_fsm (
        .clk(clk), .rst_n(rst_n), .pend_i(nmi_pend), .nmi_o(cpu_nmi));

    // maskable request output
    assign irq_any = |grp_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= irq_any;
    end

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == $past(irq_any)); // R7

    // poll summary
    always_comb begin
        summary = '0;
        summary[NUM_GRP-1:0] = grp_any;
        summary[SUM_NMI_BIT] = nmi_any;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_NMI_EN)        bus_rdata = DATA_W'(nmi_en_q);
        else if (bus_addr == A_NMI_POLL) bus_rdata = DATA_W'(nmi_req);
        else if (bus_addr == A_SUMMARY)  bus_rdata = summary;
        else if (bus_addr == A_EDGE_SEL) bus_rdata = esel_q;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (bus_addr == A_IRQ_EN0 + ADDR_W'(g))  bus_rdata = grp_en[g];
            if (bus_addr == A_IRQ_REQ0 + ADDR_W'(g)) bus_rdata = grp_req[g];
        end
    end
endmodule

// File: tb/grp_poll_intc_bench.sv
module grp_poll_intc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [4:0] ser0_evt = '0, ser1_evt = '0;
    logic       adc_evt = 0, timer_evt = 0, mute_evt = 0;
    logic       vsync_pin = 0, ext0_pin = 0, ext1_pin = 0;
    logic       cpu_irq, cpu_nmi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    grp_poll_intc u_grp_poll_intc (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ser0_evt(ser0_evt),
        .ser1_evt(ser1_evt), .adc_evt(adc_evt), .timer_evt(timer_evt),
        .mute_evt(mute_evt), .vsync_pin(vsync_pin), .ext0_pin(ext0_pin),
        .ext1_pin(ext1_pin), .cpu_irq(cpu_irq), .cpu_nmi(cpu_nmi));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // one-cycle strobe on a pulse source: group g, bit b
    task automatic pulse(input int g, input int b);
        case (g)
            0: ser0_evt[b] = 1'b1;
            1: ser1_evt[b] = 1'b1;
            2: if (b == 0) adc_evt = 1'b1; else timer_evt = 1'b1;
            default: mute_evt = 1'b1;
        endcase
        @(negedge clk);
        ser0_evt = '0; ser1_evt = '0; adc_evt = 0; timer_evt = 0; mute_evt = 0;
    endtask

    task automatic count_nmi(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (cpu_nmi) c++;
        end
    endtask

    function automatic logic [7:0] en_mask(input int r);
        case (r)
            0: return 8'h03;
            1: return 8'h1F;
            2: return 8'h1F;
            default: return 8'h0F;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        logic [7:0] ea;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        for (int r = 0; r < 4; r++) rdchk("R1 enable", 8'h10 + 8'(r), 8'h00);
        for (int g = 0; g < 3; g++) rdchk("R1 request", 8'h1C + 8'(g), 8'h00);
        rdchk("R1 nmi poll", 8'h16, 8'h00);
        rdchk("R1 summary", 8'h17, 8'h00);
        rdchk("R1 edge select", 8'h1F, 8'hFF);
        check("R1 irq", {7'b0, cpu_irq}, 8'h00);
        check("R1 nmi", {7'b0, cpu_nmi}, 8'h00);

        // R2 exhaustive enable write/readback
        for (int r = 0; r < 4; r++) begin
            ea = 8'h10 + 8'(r);
            for (int v = 0; v < 256; v++) begin
                wr(ea, 8'(v));
                rdchk("R2 enable readback", ea, 8'(v) & en_mask(r));
            end
            wr(ea, 8'h00);
        end

        // R3/R6/R7/R4 sweep over pulse sources, enabled and disabled
        for (int g = 0; g < 3; g++) begin
            for (int b = 0; b < 5; b++) begin
                if (g == 2 && (b == 1 || b == 2 || b == 4)) continue;
                for (int en = 0; en < 2; en++) begin
                    wr(8'h11 + 8'(g), en ? (8'h01 << b) : 8'h00);
                    pulse(g, b);
                    rdchk("R3 request set", 8'h1C + 8'(g), 8'h01 << b);
                    rdchk("R6 summary", 8'h17, 8'h01 << g);
                    step(1);
                    check("R7 irq level", {7'b0, cpu_irq}, 8'(en));
                    step(3);
                    check("R7 irq held", {7'b0, cpu_irq}, 8'(en));
                    wr(8'h1C + 8'(g), ~(8'h01 << b));
                    rdchk("R4 zero bits keep", 8'h1C + 8'(g), 8'h01 << b);
                    wr(8'h1C + 8'(g), 8'h01 << b);
                    rdchk("R4 cleared", 8'h1C + 8'(g), 8'h00);
                    rdchk("R6 summary clear", 8'h17, 8'h00);
                    step(1);
                    check("R7 irq drop", {7'b0, cpu_irq}, 8'h00);
                end
                wr(8'h11 + 8'(g), 8'h00);
            end
        end

        // R6 multiple members
        pulse(0, 0);
        pulse(0, 3);
        wr(8'h1C, 8'h01);
        rdchk("R6 one member left", 8'h17, 8'h01);
        wr(8'h1C, 8'h08);
        rdchk("R6 all members cleared", 8'h17, 8'h00);

        // R4 event wins over simultaneous clear
        pulse(0, 1);
        ser0_evt[1] = 1'b1;
        bus_addr = 8'h1C; bus_wdata = 8'h02; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; ser0_evt = '0;
        rdchk("R4 event beats clear", 8'h1C, 8'h02);
        wr(8'h1C, 8'h02);
        rdchk("R4 clear after collision", 8'h1C, 8'h00);

        // R5 edge pins: vsync -> 0x1E bit1, ext1 -> 0x1E bit2, ext0 -> 0x16 bit0
        for (int p = 0; p < 3; p++) begin
            logic [7:0] ra, rb, sb;
            ra = (p == 1) ? 8'h16 : 8'h1E;
            rb = (p == 0) ? 8'h02 : (p == 1) ? 8'h01 : 8'h04;
            sb = 8'h01 << p;
            case (p) 0: vsync_pin = 1; 1: ext0_pin = 1; default: ext1_pin = 1; endcase
            step(2);
            rdchk("R5 not before third edge", ra, 8'h00);
            step(1);
            rdchk("R5 rising captured", ra, rb);
            wr(ra, rb);
            case (p) 0: vsync_pin = 0; 1: ext0_pin = 0; default: ext1_pin = 0; endcase
            step(4);
            rdchk("R5 falling ignored in rising mode", ra, 8'h00);
            wr(8'h1F, ~sb);
            case (p) 0: vsync_pin = 1; 1: ext0_pin = 1; default: ext1_pin = 1; endcase
            step(4);
            rdchk("R5 rising ignored in falling mode", ra, 8'h00);
            case (p) 0: vsync_pin = 0; 1: ext0_pin = 0; default: ext1_pin = 0; endcase
            step(4);
            rdchk("R5 falling captured", ra, rb);
            wr(ra, rb);
            wr(8'h1F, 8'hFF);
        end

        // R8 NMI strobe behaviour
        pulse(3, 0);
        rdchk("R3 mute latched while disabled", 8'h16, 8'h02);
        rdchk("R6 nmi summary", 8'h17, 8'h80);
        count_nmi(6, c);
        check("R8 no strobe while disabled", 8'(c), 8'd0);
        wr(8'h10, 8'h03);
        count_nmi(6, c);
        check("R8 strobe on enabling pending", 8'(c), 8'd1);
        ext0_pin = 1;
        count_nmi(8, c);
        check("R8 no strobe while condition held", 8'(c), 8'd0);
        rdchk("R3 ext0 latched", 8'h16, 8'h03);
        wr(8'h16, 8'h02);
        rdchk("R6 nmi summary held", 8'h17, 8'h80);
        wr(8'h16, 8'h01);
        rdchk("R6 nmi summary cleared", 8'h17, 8'h00);
        ext0_pin = 0;
        step(4);
        pulse(3, 0);
        count_nmi(6, c);
        check("R8 new strobe after fall", 8'(c), 8'd1);
        wr(8'h16, 8'h03);
        wr(8'h10, 8'h00);

        // R9 writes to summary and unmapped addresses
        pulse(1, 2);
        wr(8'h17, 8'hFF);
        wr(8'h20, 8'hFF);
        wr(8'h00, 8'hFF);
        rdchk("R9 summary unchanged", 8'h17, 8'h02);
        rdchk("R9 request unchanged", 8'h1D, 8'h04);
        rdchk("R9 enable unchanged", 8'h12, 8'h00);
        rdchk("R9 edge select unchanged", 8'h1F, 8'hFF);
        rdchk("R9 unmapped read", 8'h20, 8'h00);
        rdchk("R9 unmapped read low", 8'h00, 8'h00);
        wr(8'h1D, 8'h04);
        rdchk("R9 cleanup", 8'h17, 8'h00);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule